// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table and Dispatcher

This block keeps a per-function table of interrupt message descriptors and a pending-bit array, both reachable through one 4 KiB register window on a simple 32-bit MMIO slave port. Each table entry describes one interrupt vector: a 64-bit target address, a 32-bit data word and a control word whose bit 0 masks the vector. The device raises per-vector interrupt requests. For each request the block either queues one message write (address plus data) for the outgoing handshake or, when the vector or the whole function is masked, records the request in the pending-bit array.

Software drains pending interrupts by unmasking. Any table write to a vector that is pending and is now unmasked replays that vector's message and clears its pending bit. The capability logic supplies a global enable and a function-wide mask as plain inputs. Messages leave on a valid/ready handshake. While the output stalls, queued vectors wait in a one-bit-per-vector queue and the table stays writable. The address and data of a message are taken from the table when that message is loaded into the output register.

Top module: `msix_dispatch`

## Requirements
- R1: After a synchronous reset every table word and every pending bit reads as zero and `msg_valid` is low.
- R2: Vector n occupies window offsets 16*n to 16*n+15, with the words address-low, address-high, data and control at +0x0, +0x4, +0x8 and +0xC. A 4-byte read returns the last value written, with `mmio_rvalid` high on the cycle after the request.
- R3: The pending bit of vector n reads as bit (n mod 32) of the word at 0x800 + 4*(n/32), which matches bit (n mod 8) of byte 0x800 + n/8. Reads of slots past the last vector, or of pending words past the last vector, return zero.
- R4: An access counts only when `mmio_len` is 4 and `mmio_addr[1:0]` is 0. Any other read returns zero. Writes that do not count, and all writes at offset 0x800 or above, change nothing.
- R5: A request with `irq_lvl` low, a request while `func_en` is low, and a request whose index is NUM_VEC or more are all ignored.
- R6: A request to a vector while `func_mask` is high or control bit 0 is set sets that vector's pending bit and sends no message.
- R7: A request to an unmasked vector clears its pending bit and produces exactly one message. The message address is {address-high, address-low with bits 1:0 cleared} and the data is the data word. With the output idle, `msg_valid` is high one cycle after the cycle in which the request is sampled.
- R8: After a table write to any word of a vector that is pending, the vector's message is sent and its pending bit is cleared if all of these hold: control bit 0 is now 0, `func_mask` is low and `func_en` is high.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold. Table writes are still accepted during the stall.
- R10: Queued messages are issued lowest vector index first. Address and data are taken from the table as it stood before the edge that loads the output register.
- R11: If a control write and a request to the same vector fall in one cycle, the newly written mask bit decides the request. Repeated requests to a vector whose message is queued but not yet issued produce a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| func_en | input | 1 | Global message enable from the capability logic |
| func_mask | input | 1 | Function-wide mask from the capability logic |
| mmio_req | input | 1 | MMIO access strobe, one cycle per access |
| mmio_we | input | 1 | 1 = write, 0 = read |
| mmio_addr | input | 12 | Byte offset within the window |
| mmio_len | input | 3 | Access length in bytes; only 4 is honoured |
| mmio_wdata | input | 32 | Write data |
| mmio_rvalid | output | 1 | Read data valid, one cycle after a read |
| mmio_rdata | output | 32 | Read data |
| irq_vld | input | 1 | Interrupt request strobe |
| irq_lvl | input | 1 | 1 = assert, 0 = deassert (ignored) |
| irq_idx | input | IDX_W | Requested vector index |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
Two events can land on the same clock edge: a table write that replays a pending vector, and a device request that either queues another vector or parks against a mask bit written in that same cycle. The bench drives both in one cycle, first on different vectors and then on one vector whose control word is being rewritten. A behavioural reference model, compared on every clock, then judges which messages leave and in what order, and what the pending-bit word shows. A third overlap, a grant clearing a queue bit while a new request sets it again, is provoked by stalling the output and repeating requests.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int WIN_AW = 12;

    typedef enum logic [1:0] {
        W_ADDR_LO = 2'd0,
        W_ADDR_HI = 2'd1,
        W_DATA    = 2'd2,
        W_CTRL    = 2'd3
    } word_sel_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    // Target address of a message: low word bits 1:0 always cleared.
    function automatic logic [63:0] msg_addr_f(input logic [31:0] lo, input logic [31:0] hi);
        return {hi, lo & 32'hFFFF_FFFC};
    endfunction

endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VI_W    = $clog2(NUM_VEC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [VI_W-1:0]   wr_vec,
    input  word_sel_e         wr_word,
    input  logic [31:0]       wr_data,
    input  logic [VI_W-1:0]   rd_vec,
    input  word_sel_e         rd_word,
    output logic [31:0]       rd_data,
    input  logic [VI_W-1:0]   iss_vec,
    output msg_t              iss_msg,
    output logic [NUM_VEC-1:0] mask_q
);

    logic [31:0] lo_q  [NUM_VEC];
    logic [31:0] hi_q  [NUM_VEC];
    logic [31:0] dat_q [NUM_VEC];
    logic [31:0] ctl_q [NUM_VEC];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_VEC; i++) begin
                lo_q[i]  <= '0;
                hi_q[i]  <= '0;
                dat_q[i] <= '0;
                ctl_q[i] <= '0;
            end
        end else if (wr_en) begin
            case (wr_word)
                W_ADDR_LO: lo_q[wr_vec]  <= wr_data;
                W_ADDR_HI: hi_q[wr_vec]  <= wr_data;
                W_DATA:    dat_q[wr_vec] <= wr_data;
                default:   ctl_q[wr_vec] <= wr_data;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
        assign mask_q[g] = ctl_q[g][0];
    end

    always_comb begin
        case (rd_word)
            W_ADDR_LO: rd_data = lo_q[rd_vec];
            W_ADDR_HI: rd_data = hi_q[rd_vec];
            W_DATA:    rd_data = dat_q[rd_vec];
            default:   rd_data = ctl_q[rd_vec];
        endcase
    end

    always_comb begin
        iss_msg.addr = msg_addr_f(lo_q[iss_vec], hi_q[iss_vec]);
        iss_msg.data = dat_q[iss_vec];
    end

endmodule

// File: rtl/msix_pend_ctl.sv
module msix_pend_ctl
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VI_W    = $clog2(NUM_VEC),
    parameter int IDX_W   = $clog2(NUM_VEC) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               irq_vld,
    input  logic               irq_lvl,
    input  logic [IDX_W-1:0]   irq_idx,
    input  logic               func_en,
    input  logic               func_mask,
    input  logic               wr_en,
    input  logic [VI_W-1:0]    wr_vec,
    input  word_sel_e          wr_word,
    input  logic               wr_mask_bit,
    input  logic [NUM_VEC-1:0] mask_q,
    input  logic [NUM_VEC-1:0] grant,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] send_q
);

    localparam logic [IDX_W-1:0] NV_I = IDX_W'(NUM_VEC);

    logic               irq_act;
    logic               replay_ok;
    logic [NUM_VEC-1:0] fire;
    logic [NUM_VEC-1:0] park;

    assign irq_act   = irq_vld && irq_lvl && func_en;
    assign replay_ok = func_en && !func_mask;

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        logic hit_wr;
        logic mask_eff;
        logic irq_hit;
        logic replay;
        assign hit_wr   = wr_en && (wr_vec == VI_W'(g));
        // A control write in the same cycle decides the mask (R11).
        assign mask_eff = (hit_wr && (wr_word == W_CTRL)) ? wr_mask_bit : mask_q[g];
        assign irq_hit  = irq_act && (irq_idx == IDX_W'(g));
        assign replay   = hit_wr && replay_ok && pend_q[g] && !mask_eff;
        assign fire[g]  = (irq_hit && !func_mask && !mask_eff) || replay;
        assign park[g]  = irq_hit && (func_mask || mask_eff);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            send_q <= '0;
        end else begin
            pend_q <= (pend_q & ~fire) | park;
            send_q <= (send_q & ~grant) | fire;
        end
    end

    // R6: a request under the function mask leaves its vector pending.
    assert_park_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_vld && irq_lvl && func_en && func_mask && (irq_idx < NV_I))
        |=> pend_q[$past(irq_idx[VI_W-1:0])]);

    // R5: a deassert request with no table write touches no pending bit.
    assert_deassert_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_vld && !irq_lvl && !wr_en) |=> $stable(pend_q));

    // R7: an unmasked request queues its vector and clears its pending bit.
    assert_fire_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_vld && irq_lvl && func_en && !func_mask && !wr_en && (irq_idx < NV_I)
         && !mask_q[irq_idx[VI_W-1:0]])
        |=> (send_q[$past(irq_idx[VI_W-1:0])] && !pend_q[$past(irq_idx[VI_W-1:0])]));

endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int VI_W    = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] send_q,
    input  msg_t               iss_msg,
    output logic [VI_W-1:0]    iss_vec,
    output logic [NUM_VEC-1:0] grant,
    input  logic               msg_ready,
    output logic               msg_valid,
    output msg_t               msg_q
);

    logic found;
    logic take;

    // Lowest set index wins (R10).
    always_comb begin
        iss_vec = '0;
        found   = 1'b0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (send_q[i]) begin
                iss_vec = VI_W'(i);
                found   = 1'b1;
            end
        end
    end

    assign take  = found && (!msg_valid || msg_ready);
    assign grant = take ? (NUM_VEC'(1) << iss_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            msg_q     <= '0;
        end else if (take) begin
            msg_valid <= 1'b1;
            msg_q     <= iss_msg;
        end else if (msg_ready) begin
            msg_valid <= 1'b0;
        end
    end

    // R9: a stalled message holds its fields.
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));

    // R10: at most one vector granted per cycle.
    assert_single_grant_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

// File: rtl/msix_dispatch.sv
module msix_dispatch
    import msix_pkg::*;
#(
    parameter int NUM_VEC = 8,
    parameter int IDX_W   = $clog2(NUM_VEC) + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               func_en,
    input  logic               func_mask,
    input  logic               mmio_req,
    input  logic               mmio_we,
    input  logic [WIN_AW-1:0]  mmio_addr,
    input  logic [2:0]         mmio_len,
    input  logic [31:0]        mmio_wdata,
    output logic               mmio_rvalid,
    output logic [31:0]        mmio_rdata,
    input  logic               irq_vld,
    input  logic               irq_lvl,
    input  logic [IDX_W-1:0]   irq_idx,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    localparam int VI_W      = $clog2(NUM_VEC);
    localparam int PBA_WORDS = (NUM_VEC + 31) / 32;
    localparam int PBA_BITS  = PBA_WORDS * 32;
    localparam logic [6:0] SLOT_LIM = 7'(NUM_VEC);

    logic               acc_ok;
    logic [6:0]         slot;
    logic               slot_ok;
    logic [8:0]         pba_word;
    word_sel_e          word;
    logic               wr_en;
    logic [VI_W-1:0]    slot_vec;
    logic [31:0]        tbl_rd;
    logic [31:0]        pba_val;
    logic [31:0]        rdata_d;
    logic [NUM_VEC-1:0] mask_q;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] send_q;
    logic [NUM_VEC-1:0] grant;
    logic [VI_W-1:0]    iss_vec;
    logic [PBA_BITS-1:0] pend_pad;
    msg_t               iss_msg;
    msg_t               msg_q;

    // Window decode: bit 11 selects the pending array.
    assign acc_ok   = (mmio_len == 3'd4) && (mmio_addr[1:0] == 2'b00);
    assign slot     = mmio_addr[10:4];
    assign slot_ok  = !mmio_addr[11] && (slot < SLOT_LIM);
    assign pba_word = mmio_addr[10:2];
    assign word     = word_sel_e'(mmio_addr[3:2]);
    assign slot_vec = slot[VI_W-1:0];
    assign wr_en    = mmio_req && mmio_we && acc_ok && slot_ok;
    assign pend_pad = PBA_BITS'(pend_q);

    msix_vec_table #(.NUM_VEC(NUM_VEC), .VI_W(VI_W)) i_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_vec  (slot_vec),
        .wr_word (word),
        .wr_data (mmio_wdata),
        .rd_vec  (slot_vec),
        .rd_word (word),
        .rd_data (tbl_rd),
        .iss_vec (iss_vec),
        .iss_msg (iss_msg),
        .mask_q  (mask_q)
    );

    msix_pend_ctl #(.NUM_VEC(NUM_VEC), .VI_W(VI_W), .IDX_W(IDX_W)) i_pend (
        .clk         (clk),
        .rst         (rst),
        .irq_vld     (irq_vld),
        .irq_lvl     (irq_lvl),
        .irq_idx     (irq_idx),
        .func_en     (func_en),
        .func_mask   (func_mask),
        .wr_en       (wr_en),
        .wr_vec      (slot_vec),
        .wr_word     (word),
        .wr_mask_bit (mmio_wdata[0]),
        .mask_q      (mask_q),
        .grant       (grant),
        .pend_q      (pend_q),
        .send_q      (send_q)
    );

    msix_msg_out #(.NUM_VEC(NUM_VEC), .VI_W(VI_W)) i_out (
        .clk       (clk),
        .rst       (rst),
        .send_q    (send_q),
        .iss_msg   (iss_msg),
        .iss_vec   (iss_vec),
        .grant     (grant),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_q     (msg_q)
    );

    assign msg_addr = msg_q.addr;
    assign msg_data = msg_q.data;

    always_comb begin
        pba_val = '0;
        for (int w = 0; w < PBA_WORDS; w++) begin
            if (pba_word == 9'(w)) pba_val = pend_pad[w*32 +: 32];
        end
    end

    always_comb begin
        if (!acc_ok)             rdata_d = '0;
        else if (mmio_addr[11])  rdata_d = pba_val;
        else if (slot_ok)        rdata_d = tbl_rd;
        else                     rdata_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mmio_rvalid <= 1'b0;
            mmio_rdata  <= '0;
        end else begin
            mmio_rvalid <= mmio_req && !mmio_we;
            if (mmio_req && !mmio_we) mmio_rdata <= rdata_d;
        end
    end

    // R2: read data is returned on the following cycle.
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (mmio_req && !mmio_we) |=> mmio_rvalid);

    // R4: writes into the pending-array region do not alter it.
    assert_pba_readonly_R4: assert property (@(posedge clk) disable iff (rst)
        (mmio_req && mmio_we && mmio_addr[11] && !irq_vld) |=> $stable(pend_q));

endmodule

// File: tb/test_msix_dispatch.sv
module test_msix_dispatch;

    localparam int CLK_P = 10;
    localparam int N     = 8;
    localparam int IW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        func_en = 1'b1;
    logic        func_mask = 1'b0;
    logic        mmio_req = 1'b0;
    logic        mmio_we = 1'b0;
    logic [11:0] mmio_addr = '0;
    logic [2:0]  mmio_len = 3'd4;
    logic [31:0] mmio_wdata = '0;
    logic        mmio_rvalid;
    logic [31:0] mmio_rdata;
    logic        irq_vld = 1'b0;
    logic        irq_lvl = 1'b1;
    logic [IW-1:0] irq_idx = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    msix_dispatch #(.NUM_VEC(N), .IDX_W(IW)) i_msix_dispatch (
        .clk(clk), .rst(rst), .func_en(func_en), .func_mask(func_mask),
        .mmio_req(mmio_req), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
        .mmio_len(mmio_len), .mmio_wdata(mmio_wdata),
        .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata),
        .irq_vld(irq_vld), .irq_lvl(irq_lvl), .irq_idx(irq_idx),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always #(CLK_P/2) clk = ~clk;

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    bit    started = 0;
    int    n_msgs = 0;
    string tag = "R1";

    // Reference model state
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [31:0] m_dat [N];
    logic [31:0] m_ctl [N];
    bit          m_pend [N];
    bit          m_q [N];
    bit          e_val = 0;
    logic [63:0] e_addr = '0;
    logic [31:0] e_data = '0;
    bit          e_rv = 0;
    logic [31:0] e_rd = '0;

    function automatic logic [31:0] model_read(input logic [11:0] a, input logic [2:0] len);
        logic [31:0] v;
        int s;
        v = '0;
        if (len != 3'd4 || a[1:0] != 2'b00) return '0;
        if (a[11]) begin
            for (int b = 0; b < 32; b++) begin
                if (int'(a[10:2]) * 32 + b < N) v[b] = m_pend[int'(a[10:2]) * 32 + b];
            end
            return v;
        end
        s = int'(a[10:4]);
        if (s >= N) return '0;
        case (a[3:2])
            2'd0: v = m_lo[s];
            2'd1: v = m_hi[s];
            2'd2: v = m_dat[s];
            default: v = m_ctl[s];
        endcase
        return v;
    endfunction

    always @(posedge clk) begin : model
        int pick;
        int s;
        started = 1;
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_lo[i] = '0; m_hi[i] = '0; m_dat[i] = '0; m_ctl[i] = '0;
                m_pend[i] = 0; m_q[i] = 0;
            end
            e_val = 0; e_addr = '0; e_data = '0; e_rv = 0; e_rd = '0;
        end else begin
            // output stage uses the table before this edge's write
            if (!e_val || msg_ready) begin
                pick = -1;
                for (int i = N - 1; i >= 0; i--) if (m_q[i]) pick = i;
                if (pick >= 0) begin
                    e_val  = 1;
                    e_addr = {m_hi[pick], m_lo[pick] & 32'hFFFF_FFFC};
                    e_data = m_dat[pick];
                    m_q[pick] = 0;
                    n_msgs++;
                end else begin
                    e_val = 0;
                end
            end
            e_rv = mmio_req && !mmio_we;
            if (e_rv) e_rd = model_read(mmio_addr, mmio_len);
            if (mmio_req && mmio_we && mmio_len == 3'd4 && mmio_addr[1:0] == 2'b00
                && !mmio_addr[11] && int'(mmio_addr[10:4]) < N) begin
                s = int'(mmio_addr[10:4]);
                case (mmio_addr[3:2])
                    2'd0: m_lo[s] = mmio_wdata;
                    2'd1: m_hi[s] = mmio_wdata;
                    2'd2: m_dat[s] = mmio_wdata;
                    default: m_ctl[s] = mmio_wdata;
                endcase
                if (func_en && !func_mask && m_pend[s] && !m_ctl[s][0]) begin
                    m_pend[s] = 0;
                    m_q[s] = 1;
                end
            end
            if (irq_vld && irq_lvl && func_en && int'(irq_idx) < N) begin
                if (func_mask || m_ctl[irq_idx][0]) begin
                    m_pend[irq_idx] = 1;
                end else begin
                    m_pend[irq_idx] = 0;
                    m_q[irq_idx] = 1;
                end
            end
        end
    end

    // Comparison on every clock, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            compared++;
            if (msg_valid !== e_val) begin
                mismatched++;
                $display("FAIL %s msg_valid actual=%0b expected=%0b t=%0t", tag, msg_valid, e_val, $time);
            end
            if (e_val) begin
                compared++;
                if (msg_addr !== e_addr || msg_data !== e_data) begin
                    mismatched++;
                    $display("FAIL %s message actual=%h/%h expected=%h/%h t=%0t",
                             tag, msg_addr, msg_data, e_addr, e_data, $time);
                end
            end
            compared++;
            if (mmio_rvalid !== e_rv) begin
                mismatched++;
                $display("FAIL %s mmio_rvalid actual=%0b expected=%0b t=%0t", tag, mmio_rvalid, e_rv, $time);
            end
            if (e_rv) begin
                compared++;
                if (mmio_rdata !== e_rd) begin
                    mismatched++;
                    $display("FAIL %s mmio_rdata actual=%h expected=%h t=%0t", tag, mmio_rdata, e_rd, $time);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            mismatched++;
            $display("FAIL watchdog (%s) actual=%0d cycles expected<=20000", tag, cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] len = 3'd4);
        @(negedge clk);
        mmio_req = 1; mmio_we = 1; mmio_addr = a; mmio_wdata = d; mmio_len = len;
        @(negedge clk);
        mmio_req = 0; mmio_we = 0; mmio_len = 3'd4;
    endtask

    task automatic rd(input logic [11:0] a, input logic [2:0] len = 3'd4);
        @(negedge clk);
        mmio_req = 1; mmio_we = 0; mmio_addr = a; mmio_len = len;
        @(negedge clk);
        mmio_req = 0; mmio_len = 3'd4;
    endtask

    task automatic irq(input int idx, input logic lvl = 1'b1);
        @(negedge clk);
        irq_vld = 1; irq_lvl = lvl; irq_idx = IW'(idx);
        @(negedge clk);
        irq_vld = 0; irq_lvl = 1;
    endtask

    task automatic wr_irq(input logic [11:0] a, input logic [31:0] d, input int idx);
        @(negedge clk);
        mmio_req = 1; mmio_we = 1; mmio_addr = a; mmio_wdata = d;
        irq_vld = 1; irq_idx = IW'(idx);
        @(negedge clk);
        mmio_req = 0; mmio_we = 0; irq_vld = 0;
    endtask

    initial begin
        tag = "R1";
        idle(3);
        rst = 0;
        rd(12'h000); rd(12'h00C); rd(12'h800); rd(12'h07C);

        tag = "R2";
        for (int v = 0; v < N; v++) begin
            wr(12'(v*16 + 0), 32'h1000_0003 + 32'(v*16));
            wr(12'(v*16 + 4), 32'h0000_00A0 + 32'(v));
            wr(12'(v*16 + 8), 32'h0000_D000 + 32'(v));
        end
        rd(12'h020); rd(12'h024); rd(12'h028); rd(12'h02C); rd(12'h070);

        tag = "R7";
        irq(1); idle(4);
        irq(6); idle(4);

        tag = "R6";
        wr(12'h02C, 32'h1);          // mask vector 2
        irq(2); idle(3);
        tag = "R3";
        rd(12'h800);                 // expect bit 2
        tag = "R8";
        wr(12'h02C, 32'h0);          // unmask: replay
        idle(3); rd(12'h800);

        tag = "R6";
        func_mask = 1;
        irq(3); irq(4); idle(3);
        rd(12'h800);
        func_mask = 0;
        tag = "R8";
        wr(12'h038, 32'h0000_D0D3);  // data word of vector 3: replay with new data
        idle(4); rd(12'h800);        // vector 4 still pending

        tag = "R5";
        irq(5, 1'b0); irq(8); irq(15);
        func_en = 0; irq(5); wr(12'h04C, 32'h0); func_en = 1;
        idle(4); rd(12'h800);

        tag = "R4";
        wr(12'h800, 32'hFFFF_FFFF); rd(12'h800);
        wr(12'h050, 32'h5555_5555, 3'd2); rd(12'h050);
        wr(12'h052, 32'h6666_6666); rd(12'h050);
        rd(12'h050, 3'd2); rd(12'h051);
        tag = "R3";
        rd(12'h100); rd(12'h7F0); rd(12'h804); rd(12'hFFC);

        tag = "R10";
        msg_ready = 0;
        irq(3); irq(1); irq(0);
        tag = "R9";
        wr(12'h018, 32'h0000_1111);  // table write during stall
        idle(5);
        msg_ready = 1; idle(1); msg_ready = 0; idle(3);
        msg_ready = 1; idle(5);

        tag = "R11";
        wr(12'h06C, 32'h1); irq(6);                   // vector 6 pending
        wr_irq(12'h06C, 32'h0, 5);                    // replay 6 and request 5 together
        idle(5);
        wr_irq(12'h07C, 32'h1, 7);                    // new mask governs vector 7
        idle(3); rd(12'h800);
        wr_irq(12'h06C, 32'h1, 6);                    // mask and request 6 at once
        wr_irq(12'h06C, 32'h0, 6);                    // unmask and request 6 at once
        idle(4); rd(12'h800);
        msg_ready = 0;
        irq(0); irq(2); irq(2); idle(3);
        msg_ready = 1; idle(6);

        tag = "R9";
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            msg_ready = (i % 3) != 0;
            irq_vld = (i % 2) == 0;
            irq_idx = IW'(i % N);
        end
        @(negedge clk);
        irq_vld = 0; msg_ready = 1;
        idle(12);

        compared++;
        if (n_msgs < 20) begin
            mismatched++;
            $display("FAIL R7 message count actual=%0d expected>=20", n_msgs);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule